// File: doc/BRIEF.md
# Linear Serial-Flash Read Window

This block lets a processor read serial flash as if it were plain memory. A 32-bit read port takes a word address inside a 32 MB window. The block keeps one line of 256 words in local storage. A read that falls inside that line is answered in the same cycle. A read that falls outside it starts a line fill.

For a fill, the engine selects a flash device and issues a read command through a byte-wide transfer port towards an SPI shifter. The command is an opcode, a 24-bit address, an optional mode byte and a number of zero dummy bytes. The engine then clocks in 1024 data bytes, packs them into words, releases chip select and marks the line valid. The held read is answered from the new line.

A configuration word selects the opcode, the mode byte and the dummy count, and a write to it discards the line. Two static inputs control the fill. One sets dual-parallel operation, where the window address is halved. The other sets the byte packing order.

Top module: `lin_flash_reader`

## Requirements
- R1: After reset `rd_ready` and `xfer_req` are low, `cs_n` is 2'b11, and the line is invalid, so the first read of any address starts a fill.
- R2: The configuration word resets to 0x03A002EB, so a fill with no configuration write sends opcode 0xEB, then the address, then mode byte 0xA0, then two dummy bytes.
- R3: The fill transfers are, in order: the opcode (config bits 7:0), three flash address bytes sent most significant byte first, the mode byte (bits 23:16) only when bit 25 is 1, then as many 0x00 dummy bytes as bits 10:8 give. Every data-phase transfer sends 0x00, and `xfer_tx` stays stable while a transfer waits for `xfer_done`.
- R4: A fill makes exactly (command length + 1024) transfers. `cs_n` stays low throughout and returns to 2'b11 once the last transfer completes.
- R5: Data bytes are packed four to a word, with the first received byte at bits 7:0 when `swap_bytes` is 0 and at bits 31:24 when it is 1.
- R6: The line base is the missing word address itself, not aligned. A read hits, with `rd_ready` high in the same cycle and no transfer, when its address is between base and base+255 inclusive. It returns line word (address − base). Base−1 and base+256 miss.
- R7: The flash byte address is the window byte address ({rd_waddr,2'b00}) with `dual_mode` 0, or that address shifted right by one with `dual_mode` 1. Flash address bit 24 picks the device in single mode: 0 drives `cs_n` 2'b10 and 1 drives 2'b01. In dual mode both selects go low (2'b00).
- R8: `rd_ready` stays low during a fill. The pending read is answered in the first cycle after the last transfer completes.
- R9: A configuration write invalidates the line. This includes a write in the cycle in which a fill completes, which leaves the line invalid so that the held read starts a new fill with the new configuration.
- R10: Bytes received during the command phase are dropped, so line word 0 is built only from the first four data-phase bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| dual_mode | input | 1 | Dual-parallel mode: window address halved, both selects driven |
| swap_bytes | input | 1 | Byte packing order: 0 first byte low, 1 first byte high |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_waddr | input | 23 | Word address inside the 32 MB window |
| rd_ready | output | 1 | Read answered this cycle |
| rd_data | output | 32 | Read data, valid while `rd_ready` |
| cs_n | output | 2 | Active-low device selects |
| xfer_req | output | 1 | Byte transfer requested |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | One-cycle strobe: transfer finished |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |

## Verification
Two events can land on the same edge: a configuration write and the completion of a line fill. The write must win, and the line must not become valid. To provoke this, the bench's shifter model raises `cfg_we` in exactly the cycle in which it strobes `xfer_done` for the last data byte. The outcome is judged at the ports. A second fill must follow at once, and its command bytes must come from the new configuration. The read that was held must return a word built with the new command length, and two fills must have been counted.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  localparam logic [31:0] CFG_RESET = 32'h03A0_02EB;
  localparam int DEV_BIT = 24;
  typedef enum logic {SQ_IDLE, SQ_RUN} seq_state_t;
endpackage

// File: rtl/lfr_cmd_seq.sv
module lfr_cmd_seq
  import lfr_pkg::*;
#(
  parameter int LINE_BYTES = 1024,
  localparam int IDX_W = $clog2(LINE_BYTES),
  localparam int TOT_W = $clog2(LINE_BYTES + 16)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic             mode_en,
  input  logic [7:0]       mode_byte,
  input  logic [2:0]       dummy_cnt,
  input  logic [23:0]      flash_addr,
  output logic             busy,
  output logic             xfer_req,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_done,
  input  logic [7:0]       xfer_rx,
  output logic             data_we,
  output logic [IDX_W-1:0] data_idx,
  output logic [7:0]       data_byte,
  output logic             fill_done
);
  seq_state_t st_q, st_d;
  logic [TOT_W-1:0] cnt_q, cnt_d, cmd_len;
  logic [7:0]  op_q, mode_q;
  logic        mode_en_q;
  logic [2:0]  dummy_q;
  logic [23:0] addr_q;
  logic        last;

  assign busy     = (st_q == SQ_RUN);
  assign xfer_req = busy;
  assign cmd_len  = TOT_W'(4) + TOT_W'(mode_en_q) + TOT_W'(dummy_q);
  assign last     = (cnt_q == cmd_len + TOT_W'(LINE_BYTES - 1));

  always_comb begin
    xfer_tx = 8'h00;
    case (cnt_q)
      TOT_W'(0): xfer_tx = op_q;
      TOT_W'(1): xfer_tx = addr_q[23:16];
      TOT_W'(2): xfer_tx = addr_q[15:8];
      TOT_W'(3): xfer_tx = addr_q[7:0];
      TOT_W'(4): xfer_tx = mode_en_q ? mode_q : 8'h00;
      default:   xfer_tx = 8'h00;
    endcase
  end

  assign data_we   = busy && xfer_done && (cnt_q >= cmd_len);
  assign data_idx  = IDX_W'(cnt_q - cmd_len);
  assign data_byte = xfer_rx;
  assign fill_done = busy && xfer_done && last;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!busy && start) begin
      st_d  = SQ_RUN;
      cnt_d = '0;
    end else if (busy && xfer_done) begin
      cnt_d = cnt_q + TOT_W'(1);
      if (last) st_d = SQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= '0;
      mode_q    <= '0;
      mode_en_q <= 1'b0;
      dummy_q   <= '0;
      addr_q    <= '0;
    end else if (!busy && start) begin
      op_q      <= opcode;
      mode_q    <= mode_byte;
      mode_en_q <= mode_en;
      dummy_q   <= dummy_cnt;
      addr_q    <= flash_addr;
    end
  end

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> $stable(xfer_tx));
endmodule

// File: rtl/lfr_line_buf.sv
module lfr_line_buf #(
  parameter int LINE_WORDS = 256,
  parameter int WADDR_W = 23,
  localparam int LW_W = $clog2(LINE_WORDS),
  localparam int IDX_W = LW_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   byte_idx,
  input  logic [7:0]         wbyte,
  input  logic               swap,
  input  logic               load,
  input  logic               kill,
  input  logic [WADDR_W-1:0] base_in,
  input  logic [WADDR_W-1:0] look_addr,
  output logic               hit,
  output logic [31:0]        rdata
);
  logic [31:0] mem [LINE_WORDS];
  logic               valid_q, valid_d;
  logic [WADDR_W-1:0] base_q;
  logic [WADDR_W-1:0] off;
  logic [1:0]         lane;
  logic               off_unused;

  assign lane = swap ? (2'd3 - byte_idx[1:0]) : byte_idx[1:0];

  always_ff @(posedge clk) begin
    if (we) mem[byte_idx[IDX_W-1:2]][{lane, 3'b000} +: 8] <= wbyte;
  end

  assign off        = look_addr - base_q;
  assign off_unused = ^off;
  assign hit   = valid_q && (look_addr >= base_q) &&
                 (off <= WADDR_W'(LINE_WORDS - 1));
  assign rdata = mem[off[LW_W-1:0]];

  always_comb begin
    valid_d = valid_q;
    if (load) valid_d = 1'b1;
    if (kill) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      base_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) base_q <= base_in;
    end
  end
endmodule

// File: rtl/lin_flash_reader.sv
module lin_flash_reader
  import lfr_pkg::*;
#(
  parameter int WADDR_W = 23,
  parameter int LINE_WORDS = 256,
  localparam int BADDR_W = WADDR_W + 2,
  localparam int LINE_BYTES = LINE_WORDS * 4,
  localparam int IDX_W = $clog2(LINE_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  input  logic               dual_mode,
  input  logic               swap_bytes,
  input  logic               rd_req,
  input  logic [WADDR_W-1:0] rd_waddr,
  output logic               rd_ready,
  output logic [31:0]        rd_data,
  output logic [1:0]         cs_n,
  output logic               xfer_req,
  output logic [7:0]         xfer_tx,
  input  logic               xfer_done,
  input  logic [7:0]         xfer_rx
);
  logic [31:0]        cfg_q;
  logic               stale_q, stale_d;
  logic [1:0]         cs_q, cs_d;
  logic [WADDR_W-1:0] base_hold_q;
  logic               busy, start, line_hit, fill_done;
  logic               data_we;
  logic [IDX_W-1:0]   data_idx;
  logic [7:0]         data_byte;
  logic [BADDR_W-1:0] byte_addr, flash_addr;
  logic               dev;
  logic               cfg_unused;

  assign byte_addr  = {rd_waddr, 2'b00};
  assign flash_addr = dual_mode ? (byte_addr >> 1) : byte_addr;
  assign dev        = flash_addr[DEV_BIT];
  assign cfg_unused = ^{cfg_q[31:26], cfg_q[24], cfg_q[15:11], flash_addr[1:0]};

  assign start    = rd_req && !line_hit && !busy;
  assign rd_ready = rd_req && line_hit && !busy;
  assign cs_n     = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_comb begin
    cs_d    = cs_q;
    stale_d = stale_q;
    if (start) begin
      cs_d    = dual_mode ? 2'b00 : ~(2'b01 << dev);
      stale_d = 1'b0;
    end
    if (fill_done) cs_d = 2'b11;
    if (cfg_we && busy) stale_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q        <= 2'b11;
      stale_q     <= 1'b0;
      base_hold_q <= '0;
    end else begin
      cs_q    <= cs_d;
      stale_q <= stale_d;
      if (start) base_hold_q <= rd_waddr;
    end
  end

  lfr_cmd_seq #(.LINE_BYTES(LINE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .opcode(cfg_q[7:0]), .mode_en(cfg_q[25]), .mode_byte(cfg_q[23:16]),
    .dummy_cnt(cfg_q[10:8]), .flash_addr(flash_addr[23:0]),
    .busy(busy), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx),
    .data_we(data_we), .data_idx(data_idx), .data_byte(data_byte),
    .fill_done(fill_done)
  );

  lfr_line_buf #(.LINE_WORDS(LINE_WORDS), .WADDR_W(WADDR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(data_we), .byte_idx(data_idx),
    .wbyte(data_byte), .swap(swap_bytes), .load(fill_done),
    .kill(cfg_we || start || (fill_done && stale_q)),
    .base_in(base_hold_q), .look_addr(rd_waddr),
    .hit(line_hit), .rdata(rd_data)
  );

  // R4
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n == 2'b11);
  // R4
  cs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> cs_n != 2'b11);
  // R8
  no_ready_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !xfer_req);
  // R9
  cfg_kills_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !line_hit);
endmodule

// File: tb/test_lin_flash_reader.sv
module test_lin_flash_reader;
  logic clk = 1'b0;
  logic rst_n;
  logic drv_we, coll_we;
  logic [31:0] drv_data, coll_data;
  logic cfg_we;
  logic [31:0] cfg_wdata;
  logic dual_mode, swap_bytes, rd_req;
  logic [22:0] rd_waddr;
  logic rd_ready;
  logic [31:0] rd_data;
  logic [1:0] cs_n;
  logic xfer_req, xfer_done;
  logic [7:0] xfer_tx, xfer_rx;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign cfg_we    = drv_we | coll_we;
  assign cfg_wdata = coll_we ? coll_data : drv_data;

  lin_flash_reader i_lin_flash_reader (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dual_mode(dual_mode), .swap_bytes(swap_bytes), .rd_req(rd_req),
    .rd_waddr(rd_waddr), .rd_ready(rd_ready), .rd_data(rd_data),
    .cs_n(cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // shifter model and session tracking
  logic [7:0] cmd_q[$];
  int len_q[$];
  logic [31:0] rd_q[$];
  int k = 0, cur_len = 0, sess_cnt = 0, sess_err = 0, sess_len_last = 0;
  logic [1:0] sess_cs, sess_cs_last, cs_prev;
  bit coll_arm = 0;
  logic [31:0] coll_cfg;

  initial begin
    xfer_done = 0; xfer_rx = 0; coll_we = 0; coll_data = 0;
    cs_prev = 2'b11; sess_cs = 2'b11; sess_cs_last = 2'b11;
    forever begin
      @(negedge clk);
      if (cs_prev != 2'b11 && cs_n == 2'b11) begin
        sess_len_last = k; sess_cs_last = sess_cs; sess_cnt++; k = 0;
      end
      cs_prev = cs_n;
      if (xfer_done) begin
        xfer_done = 0;
        coll_we = 0;
      end else if (xfer_req) begin
        logic [7:0] e;
        if (k == 0) begin
          cur_len = (len_q.size() != 0) ? len_q.pop_front() : 0;
          sess_cs = cs_n;
        end
        if (k < cur_len) e = (cmd_q.size() != 0) ? cmd_q.pop_front() : 8'hxx;
        else e = 8'h00;
        if (xfer_tx !== e) sess_err++;
        if (cs_n == 2'b11) sess_err++;
        if (coll_arm && k == cur_len + 1023) begin
          coll_we = 1; coll_data = coll_cfg; coll_arm = 0;
        end
        xfer_rx = 8'(k) ^ 8'hC3;
        xfer_done = 1;
        k++;
      end
    end
  end

  // read monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && rd_ready) begin
      chk(cs_n == 2'b11, "R8 ready outside fill", {30'd0, cs_n}, 32'd3);
      if (rd_q.size() == 0) chk(0, "R6 unexpected ready", rd_data, 0);
      else begin
        logic [31:0] ex;
        ex = rd_q.pop_front();
        chk(rd_data === ex, "R5/R6/R10 read data", rd_data, ex);
      end
    end
  end

  function automatic logic [31:0] exp_word(input int c, input int j, input bit s);
    logic [7:0] b[4];
    for (int i = 0; i < 4; i++) b[i] = 8'(c + 4 * j + i) ^ 8'hC3;
    return s ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]};
  endfunction

  function automatic int push_cmd(input logic [7:0] op, input logic [23:0] a,
                                  input bit men, input logic [7:0] mb,
                                  input int dum);
    int c;
    cmd_q.push_back(op);
    cmd_q.push_back(a[23:16]); cmd_q.push_back(a[15:8]); cmd_q.push_back(a[7:0]);
    if (men) cmd_q.push_back(mb);
    for (int i = 0; i < dum; i++) cmd_q.push_back(8'h00);
    c = 4 + int'(men) + dum;
    len_q.push_back(c);
    return c;
  endfunction

  task automatic write_cfg(input logic [31:0] v);
    @(posedge clk); #2;
    drv_we = 1; drv_data = v;
    @(posedge clk); #2;
    drv_we = 0;
  endtask

  // drives a read, returns cycles waited and whether cs was low the sample before
  task automatic do_read(input logic [22:0] a, input logic [31:0] ex,
                         output int waited, output bit cs_low_before);
    logic [1:0] prev;
    rd_q.push_back(ex);
    @(posedge clk); #2;
    rd_req = 1; rd_waddr = a;
    waited = 0; prev = cs_n;
    forever begin
      @(negedge clk);
      if (rd_ready) break;
      prev = cs_n; waited++;
    end
    cs_low_before = (prev != 2'b11);
    @(posedge clk); #2;
    rd_req = 0;
  endtask

  task automatic hit_read(input logic [22:0] a, input logic [31:0] ex,
                          input string tag);
    int w, s0; bit lb;
    s0 = sess_cnt;
    do_read(a, ex, w, lb);
    chk(w == 0, {tag, " hit answered same cycle"}, w, 0);
    chk(sess_cnt == s0 && !xfer_req, {tag, " hit makes no transfer"}, sess_cnt, s0);
  endtask

  task automatic miss_read(input logic [22:0] a, input logic [31:0] ex,
                           input int c, input logic [1:0] ecs, input int nfill);
    int w, s0; bit lb;
    s0 = sess_cnt; sess_err = 0;
    do_read(a, ex, w, lb);
    chk(sess_cnt == s0 + nfill, "R1/R9 fill count", sess_cnt, s0 + nfill);
    chk(sess_err == 0, "R3 command and data bytes", sess_err, 0);
    chk(sess_len_last == c + 1024, "R4 transfer count", sess_len_last, c + 1024);
    chk(sess_cs_last == ecs, "R7 chip select", sess_cs_last, ecs);
    chk(lb, "R8 answered first cycle after fill", w, 0);
  endtask

  initial begin
    int c, c2;
    rst_n = 0; drv_we = 0; drv_data = 0; dual_mode = 0; swap_bytes = 0;
    rd_req = 0; rd_waddr = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1
    chk(!rd_ready && !xfer_req, "R1 reset ready/req", {rd_ready, xfer_req}, 0);
    chk(cs_n == 2'b11, "R1 reset cs", cs_n, 2'b11);

    // R2 R3 R10: default config, first read misses
    c = push_cmd(8'hEB, 24'h000040, 1, 8'hA0, 2);
    miss_read(23'h10, exp_word(c, 0, 0), c, 2'b10, 1);
    // R6: hits at both ends of the line
    hit_read(23'h10 + 255, exp_word(c, 255, 0), "R6");
    hit_read(23'h10 + 100, exp_word(c, 100, 0), "R6");
    // R6: base-1 misses, new base unaligned
    c = push_cmd(8'hEB, 24'h00003C, 1, 8'hA0, 2);
    miss_read(23'h0F, exp_word(c, 0, 0), c, 2'b10, 1);
    hit_read(23'h0F + 255, exp_word(c, 255, 0), "R6");
    c = push_cmd(8'hEB, 24'h00043C, 1, 8'hA0, 2);
    miss_read(23'h10F, exp_word(c, 0, 0), c, 2'b10, 1);

    // R9 R3: config write invalidates; no mode, no dummy
    write_cfg(32'h0000_000B);
    c = push_cmd(8'h0B, 24'h00043C, 0, 8'h00, 0);
    miss_read(23'h10F, exp_word(c, 0, 0), c, 2'b10, 1);
    // R7: upper device
    c = push_cmd(8'h0B, 24'h000014, 0, 8'h00, 0);
    miss_read(23'h400005, exp_word(c, 0, 0), c, 2'b01, 1);
    hit_read(23'h400005 + 9, exp_word(c, 9, 0), "R6");

    // R5 R7: big-endian packing, dual mode, one dummy, mode byte
    write_cfg(32'h025A_016B);
    swap_bytes = 1; dual_mode = 1;
    c = push_cmd(8'h6B, 24'h800010, 1, 8'h5A, 1);
    miss_read(23'h400008, exp_word(c, 0, 1), c, 2'b00, 1);
    hit_read(23'h400008 + 7, exp_word(c, 7, 1), "R5");

    // R9: config write in the same cycle as fill completion
    c  = push_cmd(8'h6B, 24'h000040, 1, 8'h5A, 1);
    c2 = push_cmd(8'hEB, 24'h000040, 1, 8'hA0, 2);
    coll_cfg = 32'h03A0_02EB; coll_arm = 1;
    miss_read(23'h20, exp_word(c2, 0, 1), c2, 2'b00, 2);
    chk(c != c2 && !coll_arm, "R9 collision provoked", c2, c);

    chk(rd_q.size() == 0 && cmd_q.size() == 0, "R3/R6 scoreboard drained",
        rd_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule